// File: doc/BRIEF.md
# Toggle-on-write interrupt register unit

This unit collects four level conditions from a FIFO-based peripheral and turns them into one interrupt line. Each condition has a sticky status bit that is set when the condition rises. Software reads the status word to see which sources fired. Writing a 1 to a status bit flips that bit: a pending bit is cleared, and an idle bit can be raised from software. Writing a 0 leaves the bit as it is.

Each source is masked by its own enable bit. A single global enable then gates the whole output, and the resulting interrupt leaves the unit through a register. The FIFOs are not part of the unit. Their conditions arrive on a 4-bit input. Software reaches the unit over a simple 32-bit register port, where each access is a single-cycle strobe.

Top module: `irq_toggle_unit`

## Requirements
- R1: A synchronous active-high reset clears the status word, the per-source enables, the global enable, `irq_out` and `bus_rdata`.
- R2: A 0-to-1 change on `cond_in[i]` sets status bit i at the next clock edge. A condition that stays high does not set the bit again once software has cleared it.
- R3: The status word is at byte offset 0x20. A write there flips every status bit whose `bus_wdata` bit is 1 and leaves the bits written 0 unchanged.
- R4: When a rising condition and a toggle write hit the same status bit in the same cycle, the bit ends up set.
- R5: The per-source enables are at offset 0x28 and use the status layout. Writing 1 enables a source, writing 0 disables it, and the value reads back with bits 31..4 zero.
- R6: The global enable is bit 31 of the word at offset 0x1C. Reading that word returns only bit 31, with bits 30..0 zero.
- R7: `irq_out` is registered. It equals the OR over all sources of (status AND enable), ANDed with the global enable, as those values stood one clock edge earlier.
- R8: Status bits 31..4 always read as zero, and writing 1s to them changes nothing.
- R9: A read strobe (`bus_sel`=1, `bus_wr`=0) returns its data on `bus_rdata` in the cycle after the strobe edge. In every other cycle `bus_rdata` is zero. An unmapped offset reads as zero, and a write to an unmapped offset has no effect.
- R10: Source bit positions in both the status word and the enable word are: bit 3 read FIFO full, bit 2 write FIFO empty, bit 1 read FIFO half full, bit 0 write FIFO half full. `cond_in` uses the same positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Single-cycle access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cond_in | input | 4 | Level conditions from the FIFO logic |
| irq_out | output | 1 | Registered interrupt request |

## Verification
Register writes and condition edges take effect at the clock edge where they are presented. Read data appears after that same edge. `irq_out` follows one edge later still. The bench drives every stimulus on the falling clock edge. It reads the register words after the falling edge that follows the capturing rising edge. It checks `irq_out` both one falling edge after a change, where the old value must still hold, and two falling edges after it, where the new value must be present. This pins down the extra register stage of the interrupt path.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SRC_COUNT   = 4;
  localparam int OFF_GLOBAL  = 'h1C;
  localparam int OFF_STATUS  = 'h20;
  localparam int OFF_ENABLE  = 'h28;

  // Source positions: the status and enable words share them.
  localparam int SRC_WR_HALF  = 0;
  localparam int SRC_RD_HALF  = 1;
  localparam int SRC_WR_EMPTY = 2;
  localparam int SRC_RD_FULL  = 3;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_GLOBAL = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_ENABLE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] cond,
  output logic [NUM_SRC-1:0] rise
);
  logic [NUM_SRC-1:0] cond_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) cond_q[g] <= 1'b0;
      else     cond_q[g] <= cond[g];
    end
    assign rise[g] = cond[g] & ~cond_q[g];
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] rise,
  input  logic [NUM_SRC-1:0] tog_mask,
  output logic [NUM_SRC-1:0] status
);
  logic [NUM_SRC-1:0] status_nx;

  // Set has priority: toggle first, then OR in the rising edges.
  always_comb status_nx = (status ^ tog_mask) | rise;

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= status_nx;
  end

  // R2
  rise_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (|rise) |=> ((status & $past(rise)) == $past(rise)));

  // R3
  toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (rise == '0) |=> (status == ($past(status) ^ $past(tog_mask))));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (status == '0));
endmodule

// File: rtl/irq_regbus.sv
module irq_regbus
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [NUM_SRC-1:0] status,
  output logic [NUM_SRC-1:0] tog_mask,
  output logic [NUM_SRC-1:0] enable,
  output logic               gie,
  output logic [DATA_W-1:0]  bus_rdata
);
  localparam logic [ADDR_W-1:0] A_GLOBAL = ADDR_W'(OFF_GLOBAL);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFF_ENABLE);
  localparam int GIE_BIT = DATA_W - 1;

  reg_sel_e           sel;
  logic               do_wr;
  logic               do_rd;
  logic [DATA_W-1:0]  rd_mux;
  logic               unused_wdata_bits;

  assign unused_wdata_bits = ^bus_wdata[DATA_W-2:NUM_SRC];

  always_comb begin
    unique case (bus_addr)
      A_GLOBAL: sel = SEL_GLOBAL;
      A_STATUS: sel = SEL_STATUS;
      A_ENABLE: sel = SEL_ENABLE;
      default:  sel = SEL_NONE;
    endcase
  end

  assign do_wr = bus_sel & bus_wr;
  assign do_rd = bus_sel & ~bus_wr;

  assign tog_mask = (do_wr && sel == SEL_STATUS) ? bus_wdata[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= '0;
      gie    <= 1'b0;
    end else if (do_wr) begin
      if (sel == SEL_ENABLE) enable <= bus_wdata[NUM_SRC-1:0];
      if (sel == SEL_GLOBAL) gie    <= bus_wdata[GIE_BIT];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_GLOBAL: rd_mux[GIE_BIT]     = gie;
      SEL_STATUS: rd_mux[NUM_SRC-1:0] = status;
      SEL_ENABLE: rd_mux[NUM_SRC-1:0] = enable;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (do_rd) bus_rdata <= rd_mux;
    else            bus_rdata <= '0;
  end

  // R8
  status_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (do_rd && bus_addr == A_STATUS) |=> (bus_rdata[DATA_W-1:NUM_SRC] == '0));

  // R6
  global_lower_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (do_rd && bus_addr == A_GLOBAL) |=> (bus_rdata[GIE_BIT-1:0] == '0));

  // R9
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !do_rd |=> (bus_rdata == '0));

  // R5
  enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(do_wr && bus_addr == A_ENABLE) |=> $stable(enable));
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] status,
  input  logic [NUM_SRC-1:0] enable,
  input  logic               gie,
  output logic               irq
);
  logic [NUM_SRC-1:0] masked;
  logic               any_pend;

  assign masked   = status & enable;
  assign any_pend = |masked;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= any_pend & gie;
  end

  // R7
  gie_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !gie |=> !irq);

  // R7
  pending_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (gie && (status & enable) != '0) |=> irq);

  // R1
  irq_reset_chk: assert property (@(posedge clk)
    rst |=> !irq);
endmodule

// File: rtl/irq_toggle_unit.sv
module irq_toggle_unit #(
  parameter int NUM_SRC = irq_pkg::SRC_COUNT,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] cond_in,
  output logic               irq_out
);
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] tog_mask;
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] enable;
  logic               gie;

  irq_edge_det #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .cond (cond_in),
    .rise (rise)
  );

  irq_status_reg #(.NUM_SRC(NUM_SRC)) u_status (
    .clk      (clk),
    .rst      (rst),
    .rise     (rise),
    .tog_mask (tog_mask),
    .status   (status)
  );

  irq_regbus #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .status    (status),
    .tog_mask  (tog_mask),
    .enable    (enable),
    .gie       (gie),
    .bus_rdata (bus_rdata)
  );

  irq_out_gen #(.NUM_SRC(NUM_SRC)) u_out (
    .clk    (clk),
    .rst    (rst),
    .status (status),
    .enable (enable),
    .gie    (gie),
    .irq    (irq_out)
  );
endmodule

// File: tb/test_irq_toggle_unit.sv
module test_irq_toggle_unit;
  localparam logic [7:0] A_GLB = 8'h1C;
  localparam logic [7:0] A_ST  = 8'h20;
  localparam logic [7:0] A_EN  = 8'h28;
  localparam logic [7:0] A_BAD = 8'h24;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_sel;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  cond_in;
  logic        irq_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_toggle_unit i_irq_toggle_unit (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cond_in   (cond_in),
    .irq_out   (irq_out)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Present at a falling edge; takes effect at the following rising edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; cond_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'd0, irq_out}, 32'd0);
    check("R1 rdata idle", bus_rdata, 32'd0);
    rd(A_ST, d);  check("R1 status", d, 32'd0);
    rd(A_EN, d);  check("R1 enable", d, 32'd0);
    rd(A_GLB, d); check("R1 global", d, 32'd0);
    @(negedge clk);
    check("R9 rdata zero after read", bus_rdata, 32'd0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    cond_in = 4'b1000;                 // R10 bit 3 read FIFO full
    @(negedge clk);
    rd(A_ST, d); check("R2 rise sets bit3", d, 32'h8);
    wr(A_ST, 32'h8);
    repeat (2) @(negedge clk);
    rd(A_ST, d); check("R2 held level no reset", d, 32'h0);
    cond_in = 4'b1001;                 // R10 bit 0 write FIFO half full
    @(negedge clk);
    rd(A_ST, d); check("R2 rise sets bit0 only", d, 32'h1);
    cond_in = 4'b0000;
    wr(A_ST, 32'h1);
  endtask

  task automatic t_toggle();
    logic [31:0] d;
    wr(A_ST, 32'h5);
    rd(A_ST, d); check("R3 toggle sets", d, 32'h5);
    wr(A_ST, 32'h0);
    rd(A_ST, d); check("R3 zero keeps", d, 32'h5);
    wr(A_ST, 32'h4);
    rd(A_ST, d); check("R3 toggle clears bit2", d, 32'h1);
    wr(A_ST, 32'hFFFF_FFF0);
    rd(A_ST, d); check("R8 upper writes ignored", d, 32'h1);
    wr(A_ST, 32'hFFFF_FFFF);
    rd(A_ST, d); check("R8 upper read zero", d, 32'hE);
    wr(A_ST, 32'hE);
    rd(A_ST, d); check("R3 cleared", d, 32'h0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    cond_in = 4'b0100;
    @(negedge clk);
    cond_in = 4'b0000;
    @(negedge clk);
    rd(A_ST, d); check("R4 pre bit2 set", d, 32'h4);
    cond_in = 4'b0100;
    wr(A_ST, 32'h4);
    rd(A_ST, d); check("R4 set beats toggle", d, 32'h4);
    cond_in = 4'b0000;
    wr(A_ST, 32'h4);
    rd(A_ST, d); check("R4 cleared after", d, 32'h0);
  endtask

  task automatic t_enable_global();
    logic [31:0] d;
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, d); check("R5 enable readback", d, 32'hF);
    wr(A_EN, 32'h6);
    rd(A_EN, d); check("R5 enable pattern", d, 32'h6);
    wr(A_GLB, 32'hFFFF_FFFF);
    rd(A_GLB, d); check("R6 global set", d, 32'h8000_0000);
    wr(A_GLB, 32'h7FFF_FFFF);
    rd(A_GLB, d); check("R6 global cleared", d, 32'h0);
    wr(A_EN, 32'h0);
  endtask

  task automatic t_irq();
    wr(A_ST, 32'h2);                   // R10 bit 1 read FIFO half full
    wr(A_EN, 32'h2);
    @(negedge clk);
    check("R7 no global no irq", {31'd0, irq_out}, 32'd0);
    wr(A_GLB, 32'h8000_0000);
    check("R7 irq one edge late", {31'd0, irq_out}, 32'd0);
    @(negedge clk);
    check("R7 irq asserted", {31'd0, irq_out}, 32'd1);
    wr(A_EN, 32'h1);
    check("R7 irq holds one edge", {31'd0, irq_out}, 32'd1);
    @(negedge clk);
    check("R7 masked source drops irq", {31'd0, irq_out}, 32'd0);
    wr(A_EN, 32'h2);
    @(negedge clk);
    check("R7 re-enabled", {31'd0, irq_out}, 32'd1);
    wr(A_ST, 32'h2);
    @(negedge clk);
    check("R7 toggle clear drops irq", {31'd0, irq_out}, 32'd0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(A_ST, 32'h9);
    wr(A_BAD, 32'hFFFF_FFFF);
    rd(A_BAD, d); check("R9 unmapped read zero", d, 32'h0);
    rd(A_ST, d);  check("R9 unmapped write no effect status", d, 32'h9);
    rd(A_EN, d);  check("R9 unmapped write no effect enable", d, 32'h2);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_rise();
    t_toggle();
    t_priority();
    t_enable_global();
    t_irq();
    t_unmapped();
    do_reset();
    t_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule